// File: doc/BRIEF.md
# Masked Serial Line Write Port

This block is the write side of a line-organised video memory. A start strobe loads a target line number and a starting word position inside that line. After that, one 12-bit pixel word per clock (an 8-bit luma part and a 4-bit chroma part, taken together) is placed into a line-wide staging register at the position given by an internal pointer.

Two enables control the serial stream. The write enable moves the pointer. The capture enable decides whether the present word is stored. Dropping only the capture enable skips positions and leaves their old contents in place. When the pointer reaches the last word of a line, it stays there. A transfer strobe copies the whole staging register into the loaded line of a small on-chip line store. A combinational inspection read port returns any stored word.

Top module: `line_write_port`

## Requirements
- R1: After reset the pointer (`ptr_o`) is 0, the loaded line is 0, and every staging register entry and every line store word reads 0.
- R2: A cycle with `load_i` high sets the pointer to `bit_addr_i` (clamped to LINE_WORDS-1) and the target line to `line_addr_i` at that edge. No word is captured in that cycle, and the pointer does not advance.
- R3: On an edge with `wr_en_i` and `in_en_i` high and `load_i` low, the word {luma = `luma_i`, chroma = `chroma_i`} is stored at the current pointer position. Both parts are stored together, and the pointer then advances by one.
- R4: With `wr_en_i` high and `in_en_i` low, no word is captured, but the pointer still advances by one per edge.
- R5: With `wr_en_i` low and `load_i` low, the pointer keeps its value and nothing is captured, whatever `in_en_i` is.
- R6: At position LINE_WORDS-1 the pointer stays put on further enabled edges and never wraps. An enabled capture there overwrites the last position.
- R7: A cycle with `xfer_i` high copies all LINE_WORDS staging entries into the target line, visible at the read port after that edge. Other lines are untouched. Without a transfer, captured words never reach the line store.
- R8: A word captured in the same cycle as a transfer is included in that transfer.
- R9: Positions that were masked or not written since an earlier transfer keep their previous staging contents. A transfer writes those old values into the new line.
- R10: When `load_i` and `xfer_i` are high in the same cycle, the transfer goes to the previously loaded line.
- R11: `rd_luma_o`/`rd_chroma_o` give, without a clock, the word stored at line `rd_line_i`, position `rd_pos_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start-position load strobe |
| line_addr_i | input | LINE_AW | Target line number for the load |
| bit_addr_i | input | PTR_W | Start word position for the load |
| wr_en_i | input | 1 | Pointer advance enable |
| in_en_i | input | 1 | Word capture enable (mask when low) |
| luma_i | input | 8 | Luma part of the incoming word |
| chroma_i | input | 4 | Chroma part of the incoming word |
| xfer_i | input | 1 | Staging-to-line-store transfer strobe |
| rd_line_i | input | LINE_AW | Inspection read line |
| rd_pos_i | input | PTR_W | Inspection read position |
| rd_luma_o | output | 8 | Luma part of the inspected word |
| rd_chroma_o | output | 4 | Chroma part of the inspected word |
| ptr_o | output | PTR_W | Current write pointer |

## Verification
The hardest case to reach is stale data from an earlier line reaching a new line through R9. It needs one staging register reused across two loads with no clearing, a mask gap, and a transfer. The stimulus fills scattered positions of one line. It then reloads a different line near its end, drives the pointer into saturation, and transfers. The old words must then appear alongside the new ones. The bench also issues a transfer in the same cycle as a capture (R8), and a transfer in the same cycle as a load (R10). Both edge-coincidence orderings can then only be told apart through the read port.

// File: rtl/lwp_pkg.sv
package lwp_pkg;
    localparam int LUMA_W   = 8;
    localparam int CHROMA_W = 4;
    localparam int PIX_W    = LUMA_W + CHROMA_W;

    typedef struct packed {
        logic [LUMA_W-1:0]   luma;
        logic [CHROMA_W-1:0] chroma;
    } pix_t;
endpackage

// File: rtl/lwp_ptr_ctrl.sv
module lwp_ptr_ctrl #(
    parameter int LINE_WORDS = 16,
    parameter int NUM_LINES  = 8,
    localparam int PTR_W     = $clog2(LINE_WORDS),
    localparam int LINE_AW   = $clog2(NUM_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LINE_AW-1:0] line_addr_i,
    input  logic [PTR_W-1:0]   bit_addr_i,
    input  logic               wr_en_i,
    input  logic               in_en_i,
    output logic [PTR_W-1:0]   ptr_o,
    output logic [LINE_AW-1:0] line_o,
    output logic               capture_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic [PTR_W-1:0]   ptr;
        logic [LINE_AW-1:0] line;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.line = line_addr_i;
            st_d.ptr  = (32'(bit_addr_i) > LINE_WORDS - 1) ? LAST : bit_addr_i;
        end else if (wr_en_i && st_q.ptr != LAST) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o = wr_en_i && in_en_i && !load_i;
    assign ptr_o     = st_q.ptr;
    assign line_o    = st_q.line;
endmodule

// File: rtl/lwp_wreg.sv
module lwp_wreg
    import lwp_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    localparam int PTR_W     = $clog2(LINE_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture_i,
    input  logic [PTR_W-1:0]            ptr_i,
    input  pix_t                        pix_i,
    output logic [LINE_WORDS*PIX_W-1:0] line_next_o
);
    pix_t ent_d [LINE_WORDS];
    pix_t ent_q [LINE_WORDS];

    always_comb begin
        for (int i = 0; i < LINE_WORDS; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (capture_i) ent_d[ptr_i] = pix_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINE_WORDS; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < LINE_WORDS; i++) ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_flat
        assign line_next_o[g*PIX_W +: PIX_W] = ent_d[g];
    end
endmodule

// File: rtl/lwp_line_store.sv
module lwp_line_store
    import lwp_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    parameter int NUM_LINES  = 8,
    localparam int PTR_W     = $clog2(LINE_WORDS),
    localparam int LINE_AW   = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xfer_i,
    input  logic [LINE_AW-1:0]          xfer_line_i,
    input  logic [LINE_WORDS*PIX_W-1:0] line_data_i,
    input  logic [LINE_AW-1:0]          rd_line_i,
    input  logic [PTR_W-1:0]            rd_pos_i,
    output pix_t                        rd_pix_o
);
    pix_t mem_d [NUM_LINES][LINE_WORDS];
    pix_t mem_q [NUM_LINES][LINE_WORDS];

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int w = 0; w < LINE_WORDS; w++) begin
                mem_d[l][w] = mem_q[l][w];
            end
        end
        if (xfer_i) begin
            for (int w = 0; w < LINE_WORDS; w++) begin
                mem_d[xfer_line_i][w] = line_data_i[w*PIX_W +: PIX_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINES; l++)
                for (int w = 0; w < LINE_WORDS; w++) mem_q[l][w] <= '0;
        end else begin
            for (int l = 0; l < NUM_LINES; l++)
                for (int w = 0; w < LINE_WORDS; w++) mem_q[l][w] <= mem_d[l][w];
        end
    end

    assign rd_pix_o = mem_q[rd_line_i][rd_pos_i];
endmodule

// File: rtl/line_write_port.sv
module line_write_port
    import lwp_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    parameter int NUM_LINES  = 8,
    localparam int PTR_W     = $clog2(LINE_WORDS),
    localparam int LINE_AW   = $clog2(NUM_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [LINE_AW-1:0]  line_addr_i,
    input  logic [PTR_W-1:0]    bit_addr_i,
    input  logic                wr_en_i,
    input  logic                in_en_i,
    input  logic [LUMA_W-1:0]   luma_i,
    input  logic [CHROMA_W-1:0] chroma_i,
    input  logic                xfer_i,
    input  logic [LINE_AW-1:0]  rd_line_i,
    input  logic [PTR_W-1:0]    rd_pos_i,
    output logic [LUMA_W-1:0]   rd_luma_o,
    output logic [CHROMA_W-1:0] rd_chroma_o,
    output logic [PTR_W-1:0]    ptr_o
);
    logic [LINE_AW-1:0]          tgt_line;
    logic                        capture;
    logic [LINE_WORDS*PIX_W-1:0] line_next;
    pix_t                        in_pix;
    pix_t                        rd_pix;

    assign in_pix.luma   = luma_i;
    assign in_pix.chroma = chroma_i;

    lwp_ptr_ctrl #(.LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .line_addr_i(line_addr_i),
        .bit_addr_i(bit_addr_i), .wr_en_i(wr_en_i), .in_en_i(in_en_i),
        .ptr_o(ptr_o), .line_o(tgt_line), .capture_o(capture)
    );

    lwp_wreg #(.LINE_WORDS(LINE_WORDS)) u_wreg (
        .clk(clk), .rst_n(rst_n), .capture_i(capture), .ptr_i(ptr_o),
        .pix_i(in_pix), .line_next_o(line_next)
    );

    lwp_line_store #(.LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_store (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer_i), .xfer_line_i(tgt_line),
        .line_data_i(line_next), .rd_line_i(rd_line_i), .rd_pos_i(rd_pos_i),
        .rd_pix_o(rd_pix)
    );

    assign rd_luma_o   = rd_pix.luma;
    assign rd_chroma_o = rd_pix.chroma;
endmodule

// File: rtl/line_write_port_chk.sv
module line_write_port_chk #(
    parameter int LINE_WORDS = 16,
    localparam int PTR_W     = $clog2(LINE_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [PTR_W-1:0] bit_addr_i,
    input logic             wr_en_i,
    input logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(LINE_WORDS - 1);

    // R2
    load_sets_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && (32'(bit_addr_i) <= LINE_WORDS - 1) |=> ptr_o == $past(bit_addr_i));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !wr_en_i |=> $stable(ptr_o));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && wr_en_i && ptr_o != LAST |=> ptr_o == $past(ptr_o) + PTR_W'(1));

    // R6
    ptr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && ptr_o == LAST |=> ptr_o == LAST);
endmodule

bind line_write_port line_write_port_chk #(.LINE_WORDS(LINE_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .bit_addr_i(bit_addr_i),
    .wr_en_i(wr_en_i), .ptr_o(ptr_o)
);

// File: tb/line_write_port_tb_top.sv
module line_write_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [2:0] line_addr_i = '0;
    logic [3:0] bit_addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic       in_en_i = 1'b0;
    logic [7:0] luma_i = '0;
    logic [3:0] chroma_i = '0;
    logic       xfer_i = 1'b0;
    logic [2:0] rd_line_i = '0;
    logic [3:0] rd_pos_i = '0;
    logic [7:0] rd_luma_o;
    logic [3:0] rd_chroma_o;
    logic [3:0] ptr_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    line_write_port dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .line_addr_i(line_addr_i),
        .bit_addr_i(bit_addr_i), .wr_en_i(wr_en_i), .in_en_i(in_en_i),
        .luma_i(luma_i), .chroma_i(chroma_i), .xfer_i(xfer_i),
        .rd_line_i(rd_line_i), .rd_pos_i(rd_pos_i), .rd_luma_o(rd_luma_o),
        .rd_chroma_o(rd_chroma_o), .ptr_o(ptr_o)
    );

    typedef struct packed {
        logic       ld;
        logic [2:0] ln;
        logic [3:0] ba;
        logic       we;
        logic       ie;
        logic [7:0] y;
        logic [3:0] c;
        logic       xf;
        logic [3:0] eptr;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd2, 4'd3,  1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 4'd3,  4'd2},  // R2 load line 2 pos 3
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'hA1, 4'h1, 1'b0, 4'd4,  4'd3},  // R3 capture pos 3
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b0, 8'hB2, 4'h2, 1'b0, 4'd5,  4'd4},  // R4 mask pos 4
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'hC3, 4'h3, 1'b0, 4'd6,  4'd3},  // R3 capture pos 5
        '{1'b0, 3'd0, 4'd0,  1'b0, 1'b1, 8'hDD, 4'hD, 1'b0, 4'd6,  4'd5},  // R5 hold
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'hE5, 4'h5, 1'b1, 4'd7,  4'd8},  // R8 capture+xfer
        '{1'b1, 3'd5, 4'd14, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 4'd14, 4'd2},  // R2 load line 5 pos 14
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'h11, 4'h1, 1'b0, 4'd15, 4'd3},
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'h22, 4'h2, 1'b0, 4'd15, 4'd6},  // R6 saturate
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'h33, 4'h3, 1'b0, 4'd15, 4'd6},
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b0, 8'h44, 4'h4, 1'b1, 4'd15, 4'd7},  // R7 xfer line 5
        '{1'b0, 3'd0, 4'd0,  1'b1, 1'b1, 8'h66, 4'h6, 1'b0, 4'd15, 4'd6},
        '{1'b1, 3'd1, 4'd0,  1'b0, 1'b0, 8'h00, 4'h0, 1'b1, 4'd0,  4'd10}  // R10 load+xfer
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [2:0] l, input logic [3:0] p,
                      input logic [7:0] ey, input logic [3:0] ec);
        rd_line_i = l;
        rd_pos_i  = p;
        #1;
        chk(tag, {4'h0, rd_luma_o, rd_chroma_o}, {4'h0, ey, ec});
    endtask

    task automatic drive(input vec_t v);
        load_i = v.ld; line_addr_i = v.ln; bit_addr_i = v.ba;
        wr_en_i = v.we; in_en_i = v.ie; luma_i = v.y; chroma_i = v.c; xfer_i = v.xf;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0; wr_en_i = 1'b0; in_en_i = 1'b0; xfer_i = 1'b0;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ptr in reset", {12'h0, ptr_o}, 16'h0);
        rd("R1 store zero", 3'd3, 4'd7, 8'h00, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ptr after reset", {12'h0, ptr_o}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            chk($sformatf("R%0d ptr step %0d", VECS[i].req, i), {12'h0, ptr_o}, {12'h0, VECS[i].eptr});
            if (i == 4) rd("R7 no xfer yet", 3'd2, 4'd3, 8'h00, 4'h0);
        end

        rd("R3 line2 pos3", 3'd2, 4'd3, 8'hA1, 4'h1);
        rd("R4 line2 masked pos4", 3'd2, 4'd4, 8'h00, 4'h0);
        rd("R3 line2 pos5", 3'd2, 4'd5, 8'hC3, 4'h3);
        rd("R8 line2 pos6 same-cycle", 3'd2, 4'd6, 8'hE5, 4'h5);
        rd("R7 other line untouched", 3'd0, 4'd6, 8'h00, 4'h0);
        rd("R6 line5 pos14", 3'd5, 4'd14, 8'h11, 4'h1);
        rd("R10 line5 pos15 via load+xfer", 3'd5, 4'd15, 8'h66, 4'h6);
        rd("R9 line5 stale pos3", 3'd5, 4'd3, 8'hA1, 4'h1);
        rd("R9 line5 stale pos6", 3'd5, 4'd6, 8'hE5, 4'h5);
        rd("R10 new line not written", 3'd1, 4'd15, 8'h00, 4'h0);
        rd("R11 line2 pos0", 3'd2, 4'd0, 8'h00, 4'h0);

        // R7 captures without transfer never reach the store
        drive('{1'b0, 3'd0, 4'd0, 1'b1, 1'b1, 8'h77, 4'h7, 1'b0, 4'd1, 4'd7});
        drive('{1'b0, 3'd0, 4'd0, 1'b1, 1'b1, 8'h78, 4'h8, 1'b0, 4'd2, 4'd7});
        rd("R7 line1 pos0 before xfer", 3'd1, 4'd0, 8'h00, 4'h0);
        chk("R3 ptr after two captures", {12'h0, ptr_o}, 16'h2);
        drive('{1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 8'h00, 4'h0, 1'b1, 4'd2, 4'd7});
        rd("R7 line1 pos1 after xfer", 3'd1, 4'd1, 8'h78, 4'h8);
        rd("R11 line1 pos0 after xfer", 3'd1, 4'd0, 8'h77, 4'h7);

        // R1 reset mid-run clears store and pointer
        rst_n = 1'b0;
        @(negedge clk);
        rd("R1 store cleared", 3'd5, 4'd15, 8'h00, 4'h0);
        chk("R1 ptr cleared", {12'h0, ptr_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule